// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block sits beside a small stack CPU and decides when that CPU must break off to serve an interrupt. It has eight levels with fixed priority: level 7 is highest and level 0 is lowest. Two 8-bit registers hold the state. The pending register logs requests. The active register records which levels are being serviced. A level is taken only when it ranks above every level already in service, so service routines nest strictly by priority.

Hardware request lines are sampled on each instruction-cycle strobe that is not flagged as an I/O instruction. Software can OR any set of bits into the pending register through a write port, and those bits are then treated like hardware requests. When the CPU's global enable flag is set and an eligible level exists, the block raises a one-cycle acknowledge together with that level's 12-bit service address. A return-from-interrupt strobe ends service of the most recent, highest level. After reset is released, the block issues one acknowledge carrying the start-up address 008h.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is asserted, `ack_o` is 0 and `vec_o` is 000h, and the pending and active registers are cleared. The first clock edge after release gives `ack_o`=1 with `vec_o`=008h for exactly one cycle. No request logged before the reset is serviced after it.
- R2: `req_i` is ORed into the pending register at an edge where `cyc_i`=1 and `io_cyc_i`=0. At an edge where `cyc_i`=0 or `io_cyc_i`=1, `req_i` has no effect.
- R3: At an edge where `swi_we_i`=1, bit n of `swi_bits_i` sets pending level n, with or without `cyc_i`. Such a level is then serviced exactly like a hardware request.
- R4: No acknowledge is issued while `gie_i`=0. Pending levels stay logged while `gie_i`=0 and are serviced once `gie_i`=1.
- R5: A level can be acknowledged only if it is pending and ranks above every set active bit. Among such levels, the highest one wins. The acknowledge is issued at an edge where `cyc_i`=1, `io_cyc_i`=0, `gie_i`=1 and `ack_o` is currently 0.
- R6: Level n for n=0..6 is given the address 040h·(n+1). Level 7 is given 1E0h.
- R7: An acknowledge sets the active bit of the chosen level. `ack_o` is high for exactly one cycle, and the vector is valid while `ack_o` is high.
- R8: At an edge where `rti_i`=1, the highest set active bit and the pending bit of the same level are cleared, and no other bit changes. Repeated returns therefore unwind nested levels from the top down.
- R9: A request for a level whose pending bit is already set is merged into that bit. It produces no second service.
- R10: If an edge both clears a level through `rti_i` and samples a new request for that same level, the new request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| req_i | input | 8 | Hardware request lines, bit n = level n |
| gie_i | input | 1 | Global interrupt enable flag from the CPU |
| cyc_i | input | 1 | Instruction-cycle strobe |
| io_cyc_i | input | 1 | Current instruction is an I/O instruction |
| swi_we_i | input | 1 | Software-interrupt write strobe |
| swi_bits_i | input | 8 | Levels to set pending on a software write |
| rti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | Interrupt acknowledge request to the CPU (one cycle) |
| vec_o | output | 12 | Service address, valid while `ack_o` is high |

## Verification
The hardest state to reach is one where a lower level is in service, a higher level is taken on top of it, and a request for a level between the two arrives and must wait. The only things the bench can see are `ack_o` and `vec_o`. The stimulus builds this state from the ports: it raises requests one cycle apart, with `gie_i` set, so that each acknowledge lands before the next request. Returns are then issued one at a time. The bench checks that the waiting middle level is taken only after the top level has returned, and ahead of the bottom level. A separate step puts a return and a fresh request for the same level on the same edge, and checks that the level is served a second time.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned VAW = 12;
  typedef logic [VAW-1:0] vaddr_t;

  function automatic vaddr_t lvl_vector(int unsigned lvl, int unsigned nlvl,
                                        vaddr_t step, vaddr_t last);
    if (lvl + 1 >= nlvl) return last;
    return vaddr_t'(step * vaddr_t'(lvl + 1));
  endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned NLVL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_en,
  input  logic [NLVL-1:0] req_i,
  input  logic            sw_we,
  input  logic [NLVL-1:0] sw_bits,
  input  logic [NLVL-1:0] clr_mask,
  output logic [NLVL-1:0] pend_q
);
  logic [NLVL-1:0] pend_d;
  logic            load_en;

  // a fresh sample is ORed in after the clear, so it survives a same-edge return (R10)
  always_comb begin
    pend_d = pend_q & ~clr_mask;
    if (smp_en) pend_d = pend_d | req_i;
    if (sw_we)  pend_d = pend_d | sw_bits;
    load_en = smp_en | sw_we | (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (load_en) pend_q <= pend_d;
  end

  p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_en && !sw_we && clr_mask == '0) |=> $stable(pend_q));

  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned NLVL = 8,
  localparam int unsigned LW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] pend,
  input  logic [NLVL-1:0] act,
  output logic            cand_vld,
  output logic [LW-1:0]   cand_idx
);
  logic [NLVL-1:0] elig;

  // a level is eligible only when no active bit sits at or above it
  for (genvar g = 0; g < NLVL; g++) begin : g_elig
    assign elig[g] = pend[g] & ~(|act[NLVL-1:g]);
  end

  always_comb begin
    cand_vld = 1'b0;
    cand_idx = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (elig[i]) begin
        cand_vld = 1'b1;
        cand_idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_act_reg.sv
module irq_act_reg #(
  parameter int unsigned NLVL = 8,
  localparam int unsigned LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [LW-1:0]   set_idx,
  input  logic            rti_i,
  output logic [NLVL-1:0] act_q,
  output logic [NLVL-1:0] clr_mask
);
  logic [NLVL-1:0] top_oh;
  logic [NLVL-1:0] set_oh;
  logic [NLVL-1:0] act_d;
  logic            load_en;

  always_comb begin
    top_oh = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (act_q[i]) top_oh = NLVL'(1) << i;
    end
    clr_mask = rti_i ? top_oh : '0;
    set_oh   = set_en ? (NLVL'(1) << set_idx) : '0;
    act_d    = (act_q & ~clr_mask) | set_oh;
    load_en  = set_en | (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= '0;
    else if (load_en) act_q <= act_d;
  end

  p_one_new_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ($countones(act_q & ~$past(act_q)) == 1));

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> ((act_q & ~$past(act_q)) == '0));

  p_rti_unwind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_mask) && !set_en) |=>
      ($countones(act_q) + 1 == $countones($past(act_q))));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned     NLVL     = 8,
  parameter irq_pkg::vaddr_t VEC_STEP = 12'h040,
  parameter irq_pkg::vaddr_t VEC_TOP  = 12'h1E0,
  parameter irq_pkg::vaddr_t VEC_BOOT = 12'h008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req_i,
  input  logic        gie_i,
  input  logic        cyc_i,
  input  logic        io_cyc_i,
  input  logic        swi_we_i,
  input  logic [7:0]  swi_bits_i,
  input  logic        rti_i,
  output logic        ack_o,
  output logic [11:0] vec_o
);
  localparam int unsigned LW = $clog2(NLVL);

  logic [NLVL-1:0]  pend_q;
  logic [NLVL-1:0]  act_q;
  logic [NLVL-1:0]  clr_mask;
  logic             cand_vld;
  logic [LW-1:0]    cand_idx;
  logic             smp_en;
  logic             take;
  logic             boot_q;
  logic             ack_q;
  logic             ack_d;
  irq_pkg::vaddr_t  vec_q;
  irq_pkg::vaddr_t  vec_d;
  logic             vec_en;
  irq_pkg::vaddr_t  vec_lut [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_vec
    assign vec_lut[g] = irq_pkg::lvl_vector(g, NLVL, VEC_STEP, VEC_TOP);
  end

  assign smp_en = cyc_i & ~io_cyc_i;

  irq_pend_reg #(.NLVL(NLVL)) pend_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .req_i    (req_i),
    .sw_we    (swi_we_i),
    .sw_bits  (swi_bits_i),
    .clr_mask (clr_mask),
    .pend_q   (pend_q)
  );

  irq_prio_sel #(.NLVL(NLVL)) sel_i (
    .pend     (pend_q),
    .act      (act_q),
    .cand_vld (cand_vld),
    .cand_idx (cand_idx)
  );

  irq_act_reg #(.NLVL(NLVL)) act_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (take),
    .set_idx  (cand_idx),
    .rti_i    (rti_i),
    .act_q    (act_q),
    .clr_mask (clr_mask)
  );

  // next-state: start-up call first, then priority acknowledges
  always_comb begin
    take   = smp_en & gie_i & cand_vld & ~ack_q & ~boot_q;
    ack_d  = boot_q | take;
    vec_en = boot_q | take;
    vec_d  = boot_q ? VEC_BOOT : vec_lut[cand_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      ack_q  <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      ack_q  <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign ack_o = ack_q;
  assign vec_o = vec_q;

  p_boot_call_r1: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> (ack_q && vec_q == VEC_BOOT));

  p_gie_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_i && !boot_q) |=> !ack_q);

  p_vec_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (vec_q == VEC_BOOT || vec_q[5:0] == 6'd0 || vec_q == VEC_TOP));

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  p_act_in_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q & ~pend_q) == '0);
endmodule

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  req_i;
  logic        gie_i, cyc_i, io_cyc_i, swi_we_i, rti_i;
  logic [7:0]  swi_bits_i;
  logic        ack_o;
  logic [11:0] vec_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .gie_i(gie_i), .cyc_i(cyc_i),
    .io_cyc_i(io_cyc_i), .swi_we_i(swi_we_i), .swi_bits_i(swi_bits_i),
    .rti_i(rti_i), .ack_o(ack_o), .vec_o(vec_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        cyc;
    logic        io;
    logic        gie;
    logic        swe;
    logic [7:0]  sb;
    logic        rti;
    logic        eack;
    logic [11:0] evec;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 45;
  // fields: req cyc io gie swe swbits rti | exp_ack exp_vec | requirement
  localparam vec_t TBL [NV] = '{
    '{8'h04,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd4}, // R4 log L2 while disabled
    '{8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd4}, // R4 still held off
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h0C0,4'd4}, // R4 served after enable
    '{8'h01,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd7}, // R7 single-cycle ack
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd5}, // R5 L0 below active L2
    '{8'h20,1'b1,1'b1,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd2}, // R2 I/O cycle
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd2}, // R2 L5 not logged
    '{8'h20,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd2}, // R2 no strobe
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd2}, // R2 L5 not logged
    '{8'h00,1'b0,1'b0,1'b1,1'b1,8'h80,1'b0, 1'b0,12'h000,4'd3}, // R3 software L7
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h1E0,4'd3}, // R3 nests over L2
    '{8'h80,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd9}, // R9 L7 again while pending
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8}, // R8 return L7
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd9}, // R9 no second L7
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8}, // R8 return L2
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h040,4'd6}, // R6 L0
    '{8'h01,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd10},// R10 return + request L0
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h040,4'd10},// R10 L0 again
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd8}, // R8 all clear
    '{8'h00,1'b0,1'b0,1'b1,1'b1,8'h7E,1'b0, 1'b0,12'h000,4'd3}, // R3 L1..L6
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h1C0,4'd6}, // R6 L6
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h180,4'd6}, // R6 L5
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h140,4'd6}, // R6 L4
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h100,4'd6}, // R6 L3
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h0C0,4'd6}, // R6 L2
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h080,4'd6}, // R6 L1
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd8},
    '{8'h02,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd2}, // R2 log L1
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h080,4'd5}, // R5 L1
    '{8'h10,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd7},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h140,4'd5}, // R5 L4 nests over L1
    '{8'h08,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd7},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd5}, // R5 L3 waits under L4
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8}, // R8 return L4
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b1,12'h100,4'd5}, // R5 L3 over L1
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,12'h000,4'd8}, // R8 return L1
    '{8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,12'h000,4'd8}
  };

  task automatic drive(input vec_t v);
    req_i = v.req; cyc_i = v.cyc; io_cyc_i = v.io; gie_i = v.gie;
    swi_we_i = v.swe; swi_bits_i = v.sb; rti_i = v.rti;
  endtask

  task automatic idle(input logic gie);
    req_i = '0; cyc_i = 1'b1; io_cyc_i = 1'b0; gie_i = gie;
    swi_we_i = 1'b0; swi_bits_i = '0; rti_i = 1'b0;
  endtask

  task automatic check(input string rq, input logic eack, input logic [11:0] evec,
                       input bit cmp_vec);
    n_vec++;
    if (ack_o !== eack || (cmp_vec && vec_o !== evec)) begin
      n_bad++;
      $display("FAIL %s: ack=%0b vec=%03h expected ack=%0b vec=%03h",
               rq, ack_o, vec_o, eack, evec);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle(1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 1'b0, 12'h000, 1'b1);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 start-up call", 1'b1, 12'h008, 1'b1);
    idle(1'b0);
    @(posedge clk); @(negedge clk);
    check("R1 start-up pulse ends", 1'b0, 12'h000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(posedge clk); @(negedge clk);
      check($sformatf("R%0d step %0d", TBL[i].rq, i), TBL[i].eack, TBL[i].evec,
            TBL[i].eack);
    end

    // R1: a level logged before reset must not survive it
    idle(1'b0);
    swi_we_i = 1'b1; swi_bits_i = 8'h08; cyc_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 pre-reset log", 1'b0, 12'h000, 1'b0);
    idle(1'b0);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 reset mid-run", 1'b0, 12'h000, 1'b1);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 start-up call again", 1'b1, 12'h008, 1'b1);
    idle(1'b1);
    @(posedge clk); @(negedge clk);
    check("R1 cleared pending", 1'b0, 12'h000, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R1 cleared pending", 1'b0, 12'h000, 1'b0);

    // R3 with R5: software level taken in the same way as hardware, highest first
    idle(1'b1);
    swi_we_i = 1'b1; swi_bits_i = 8'h81; cyc_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 write only", 1'b0, 12'h000, 1'b0);
    idle(1'b1);
    @(posedge clk); @(negedge clk);
    check("R5 highest of two", 1'b1, 12'h1E0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule